// File: doc/BRIEF.md
# Sliding-Window Sorted List

This block keeps the sixteen most recent 6-bit samples it has accepted, held in ascending order. A caller reads any rank of that order by placing a 4-bit position on `sel_index`. Position 0 is the smallest value and position 15 the largest. The read path is combinational from the list registers, so a new position gives a new value without waiting for a clock edge.

Each sorted slot carries an age tag. When a sample is accepted, the control FSM runs two steps. In the first, the slot whose tag marks it as the oldest is removed, and the entries above it close the gap. In the second, the new value goes in at the position given by the number of remaining entries that are less than or equal to it, and the larger entries move up one slot. A new sample therefore lands after every older entry of equal value.

One input code, 6'b101010, is never stored. It resets the window to sixteen zero entries, each with a fresh age order, and the following samples push those zeros out one at a time. The sample cadence is fixed at three cycles: the block drops `ready` for the two cycles of an update. Samples offered while `ready` is low are ignored.

Top module: `swin_sorted_window`

## Requirements
- R1: While `rst` is high and after it falls, all 16 list positions read zero and `ready` is high.
- R2: `nth_value` equals the list entry at position `sel_index` (bit 0 is the LSB of both), and follows `sel_index` without a clock edge.
- R3: The list is kept in ascending order: position i is never larger than position i+1.
- R4: After each update the list holds exactly the 16 most recent non-clear samples accepted since the last reset or clear, filled with zeros where fewer than 16 have arrived. The oldest entry is the one removed.
- R5: A sample is accepted on a rising edge where `in_valid` and `ready` are both high. For a non-clear sample, `ready` is low for exactly the next two cycles and high again in the third, and the updated list is visible from that point.
- R6: An accepted sample equal to 6'b101010 sets all 16 positions to zero one cycle later, is not stored, and leaves `ready` high.
- R7: A sample offered while `ready` is low has no effect on the list, including the clear code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_value | input | 6 | Sample value, unsigned |
| sel_index | input | 4 | Sorted position to read |
| nth_value | output | 6 | Value at the selected sorted position |
| ready | output | 1 | High when a sample can be accepted and the list is settled |

## Verification
The bench targets the following corner cases:
- **Duplicate values.** A wrong tie rule or an off-by-one in the insert position leaves a gap, or leaves one value twice.
- **Evicting the oldest entry when it sits at either end of the order.** A design that evicts by position instead of by age drops the wrong value.
- **The first sixteen samples after a clear.** A design that mishandles the fresh age order keeps a stale zero or loses a real sample.
- **Samples that arrive mid-update.** These include the clear code, which a careless handshake would latch or act on.
- **Values next to the clear code and at the range ends.** These expose a decoder that matches too widely.

// File: rtl/swin_pkg.sv
package swin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_INSERT = 2'd2,
    ST_DONE   = 2'd3
  } swin_state_e;

  // Position at which a new value goes: the number of live entries that are
  // less than or equal to it, so it lands after older equal entries.
  function automatic int unsigned rank_after_equals(input int unsigned le_count);
    return le_count;
  endfunction
endpackage

// File: rtl/swin_ctrl.sv
module swin_ctrl
  import swin_pkg::*;
#(
  parameter int DW = 6,
  parameter logic [DW-1:0] CLEAR_CODE = 6'b101010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_value,
  output swin_state_e   state,
  output logic          ready,
  output logic          clear_req,
  output logic          evict_go,
  output logic          insert_go,
  output logic [DW-1:0] pend_value
);
  swin_state_e state_d;
  logic        accept;
  logic        load_req;

  assign ready     = (state == ST_IDLE) || (state == ST_DONE);
  assign accept    = in_valid && ready;
  assign clear_req = accept && (in_value == CLEAR_CODE);
  assign load_req  = accept && (in_value != CLEAR_CODE);
  assign evict_go  = (state == ST_EVICT);
  assign insert_go = (state == ST_INSERT);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (load_req)       state_d = ST_EVICT;
        else if (clear_req) state_d = ST_DONE;
        else                state_d = ST_IDLE;
      end
      ST_EVICT:  state_d = ST_INSERT;
      ST_INSERT: state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pend_value <= '0;
    end else begin
      state <= state_d;
      if (load_req) pend_value <= in_value;
    end
  end

  // R5: an update always takes exactly the evict step then the insert step
  p_evict_then_insert_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVICT) |=> (state == ST_INSERT));
  p_insert_then_done_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INSERT) |=> (state == ST_DONE));
  // R7: nothing arriving mid-update disturbs the held sample
  p_busy_holds_sample_r7: assert property (@(posedge clk) disable iff (rst)
    (!ready && !$past(rst)) |=> $stable(pend_value));
endmodule

// File: rtl/swin_locate.sv
module swin_locate
  import swin_pkg::*;
#(
  parameter int DW    = 6,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DW-1:0] vals,
  input  logic [DEPTH-1:0][IW-1:0] ages,
  input  logic [DW-1:0]            new_val,
  output logic [IW-1:0]            evict_pos,
  output logic [IW-1:0]            ins_pos,
  output logic                     oldest_found
);
  localparam logic [IW-1:0] OLDEST_TAG = IW'(DEPTH - 1);

  logic [DEPTH-1:0] is_oldest;
  logic [DEPTH-2:0] not_above;

  // one comparator pair per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign is_oldest[g] = (ages[g] == OLDEST_TAG);
    if (g < DEPTH - 1) begin : g_live
      assign not_above[g] = (vals[g] <= new_val);
    end
  end

  always_comb begin
    evict_pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (is_oldest[i]) evict_pos = IW'(i);
    end
  end

  always_comb begin
    int unsigned cnt;
    cnt = 0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (not_above[i]) cnt = cnt + 1;
    end
    ins_pos = IW'(rank_after_equals(cnt));
  end

  assign oldest_found = |is_oldest;
endmodule

// File: rtl/swin_store.sv
module swin_store #(
  parameter int DW    = 6,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter logic [DW-1:0] CLEAR_CODE = 6'b101010
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear_req,
  input  logic                     evict_go,
  input  logic                     insert_go,
  input  logic [IW-1:0]            evict_pos,
  input  logic [IW-1:0]            ins_pos,
  input  logic [DW-1:0]            new_val,
  output logic [DEPTH-1:0][DW-1:0] vals,
  output logic [DEPTH-1:0][IW-1:0] ages
);
  logic [DW-1:0] val_d [DEPTH];
  logic [IW-1:0] age_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IW-1:0] GI = IW'(g);
    logic [DW-1:0] up_val, dn_val;
    logic [IW-1:0] up_age, dn_age;

    if (g < DEPTH - 1) begin : g_up
      assign up_val = vals[g+1];
      assign up_age = ages[g+1];
    end else begin : g_top
      assign up_val = vals[g];
      assign up_age = ages[g];
    end
    if (g > 0) begin : g_dn
      assign dn_val = vals[g-1];
      assign dn_age = ages[g-1];
    end else begin : g_bot
      assign dn_val = vals[g];
      assign dn_age = ages[g];
    end

    always_comb begin
      val_d[g] = vals[g];
      age_d[g] = ages[g];
      if (evict_go) begin
        if (GI >= evict_pos) begin
          val_d[g] = up_val;
          age_d[g] = up_age;
        end
      end else if (insert_go) begin
        if (GI == ins_pos) begin
          val_d[g] = new_val;
          age_d[g] = '0;
        end else if (GI > ins_pos) begin
          val_d[g] = dn_val;
          age_d[g] = dn_age + IW'(1);
        end else begin
          age_d[g] = ages[g] + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst || clear_req) begin
        vals[i] <= '0;
        ages[i] <= IW'(i);
      end else begin
        vals[i] <= val_d[i];
        ages[i] <= age_d[i];
      end
    end
  end

  // assertion support: order, forbidden code, age coverage
  logic             order_ok;
  logic             code_absent;
  logic             all_zero;
  logic [DEPTH-1:0] age_seen;
  always_comb begin
    order_ok    = 1'b1;
    code_absent = 1'b1;
    all_zero    = 1'b1;
    age_seen    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < DEPTH - 1 && vals[i] > vals[i+1]) order_ok = 1'b0;
      if (vals[i] == CLEAR_CODE) code_absent = 1'b0;
      if (vals[i] != '0) all_zero = 1'b0;
      age_seen[ages[i]] = 1'b1;
    end
  end

  p_sorted_r3: assert property (@(posedge clk) disable iff (rst) order_ok);
  p_no_clear_code_r6: assert property (@(posedge clk) disable iff (rst) code_absent);
  p_clear_zeroes_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clear_req)) |-> all_zero);
  p_ages_distinct_r4: assert property (@(posedge clk) disable iff (rst)
    !insert_go |-> ($countones(age_seen) == DEPTH));
endmodule

// File: rtl/swin_sorted_window.sv
module swin_sorted_window
  import swin_pkg::*;
#(
  parameter int DW    = 6,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter logic [DW-1:0] CLEAR_CODE = 6'b101010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_value,
  input  logic [IW-1:0] sel_index,
  output logic [DW-1:0] nth_value,
  output logic          ready
);
  swin_state_e             state;
  logic                    clear_req, evict_go, insert_go, oldest_found;
  logic [DW-1:0]           pend_value;
  logic [IW-1:0]           evict_pos, ins_pos;
  logic [DEPTH-1:0][DW-1:0] vals;
  logic [DEPTH-1:0][IW-1:0] ages;

  swin_ctrl #(.DW(DW), .CLEAR_CODE(CLEAR_CODE)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
    .state(state), .ready(ready), .clear_req(clear_req),
    .evict_go(evict_go), .insert_go(insert_go), .pend_value(pend_value)
  );

  swin_locate #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_locate (
    .vals(vals), .ages(ages), .new_val(pend_value),
    .evict_pos(evict_pos), .ins_pos(ins_pos), .oldest_found(oldest_found)
  );

  swin_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW), .CLEAR_CODE(CLEAR_CODE)) u_store (
    .clk(clk), .rst(rst), .clear_req(clear_req),
    .evict_go(evict_go), .insert_go(insert_go),
    .evict_pos(evict_pos), .ins_pos(ins_pos), .new_val(pend_value),
    .vals(vals), .ages(ages)
  );

  // R2: read path straight from the list registers
  assign nth_value = vals[sel_index];

  // R4: an oldest entry always exists when eviction runs
  p_oldest_exists_r4: assert property (@(posedge clk) disable iff (rst)
    evict_go |-> oldest_found);
endmodule

// File: tb/tb_swin_sorted_window.sv
`timescale 1ns/1ps
module tb_swin_sorted_window;
  localparam int DW = 6;
  localparam int DEPTH = 16;
  localparam int IW = 4;
  localparam logic [DW-1:0] CLR = 6'b101010;
  typedef logic [DW-1:0] arr_t [DEPTH];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_value = '0;
  logic [IW-1:0] sel_index = '0;
  logic [DW-1:0] nth_value;
  logic ready;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  arr_t hist;  // hist[DEPTH-1] is the newest

  always #2.5 clk = ~clk;

  swin_sorted_window dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
    .sel_index(sel_index), .nth_value(nth_value), .ready(ready)
  );

  function automatic arr_t sorted_of(arr_t a);
    arr_t s = a;
    for (int i = 1; i < DEPTH; i++) begin
      for (int j = i; j > 0; j--) begin
        if (s[j-1] > s[j]) begin
          logic [DW-1:0] t = s[j];
          s[j] = s[j-1];
          s[j-1] = t;
        end
      end
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: each position is read by changing sel_index only, no clock edge needed
  task automatic compare_list(string req);
    arr_t s = sorted_of(hist);
    for (int i = 0; i < DEPTH; i++) begin
      sel_index = IW'(i);
      #0.1;
      check(nth_value == s[i], req, int'(nth_value), int'(s[i]));
    end
  endtask

  task automatic model_take(logic [DW-1:0] v);
    if (v == CLR) begin
      for (int i = 0; i < DEPTH; i++) hist[i] = '0;
    end else begin
      for (int i = 0; i < DEPTH - 1; i++) hist[i] = hist[i+1];
      hist[DEPTH-1] = v;
    end
  endtask

  // offer one sample; optionally poke the busy window with junk (R7)
  task automatic push(logic [DW-1:0] v, bit poke);
    @(negedge clk);
    check(ready == 1'b1, "R5 ready before sample", int'(ready), 1);
    in_valid = 1'b1;
    in_value = v;
    @(negedge clk);
    in_valid = 1'b0;
    model_take(v);
    if (v == CLR) begin
      check(ready == 1'b1, "R6 ready stays high on clear", int'(ready), 1);
      compare_list("R6 list after clear");
    end else begin
      check(ready == 1'b0, "R5 busy cycle 1", int'(ready), 0);
      if (poke) begin in_valid = 1'b1; in_value = CLR; end
      @(negedge clk);
      check(ready == 1'b0, "R5 busy cycle 2", int'(ready), 0);
      if (poke) begin in_valid = 1'b1; in_value = 6'h3F; end
      @(negedge clk);
      in_valid = 1'b0;
      check(ready == 1'b1, "R5 ready back", int'(ready), 1);
      compare_list(poke ? "R7 list after busy pokes" : "R4 R3 list after insert");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_value = 6'd17;
    @(negedge clk);
    @(negedge clk);
    check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) hist[i] = '0;
    @(negedge clk);
    check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    compare_list("R1 zero list after reset");
  endtask

  initial begin
    int unsigned seed = 32'd20240314;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) hist[i] = '0;
    do_reset();
    // directed: duplicates, extremes, neighbours of the clear code
    push(6'd10, 0); push(6'd3, 0); push(6'd3, 1); push(6'd63, 0);
    push(6'd0, 0); push(6'd41, 0); push(6'd43, 1);
    push(CLR, 0);                     // R6
    push(6'd5, 0);                    // back to back after clear
    for (int k = 0; k < 20; k++) push(6'(40 - k), 0);   // R4 wrap past 16
    for (int k = 0; k < 18; k++) push(6'(k % 3), k % 5 == 0);  // heavy ties
    push(CLR, 0);
    push(CLR, 0);
    for (int k = 0; k < 17; k++) push(6'd63, 0);  // R4 all zeros evicted
    do_reset();
    // constrained random: small range every third sample for ties
    for (int k = 0; k < 160; k++) begin
      logic [DW-1:0] v;
      v = (k % 3 == 0) ? 6'($urandom_range(0, 7)) : 6'($urandom_range(0, 63));
      if ($urandom_range(0, 24) == 0) v = CLR;
      push(v, $urandom_range(0, 5) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule